// File: doc/BRIEF.md
# Spread Spectrum Modulation Profile Generator

This block runs on the reference clock and produces a signed frequency-offset word. A downstream fractional divider or numerically controlled oscillator uses this word to sweep an output clock around its nominal frequency, which spreads the clock's energy over a band. The offset follows a linear triangle. It starts each modulation period at its minimum, climbs to its maximum at mid-period and falls back. The period is a power-of-two number of reference cycles, and the range select picks it.

Two three-level spread pins choose one of nine settings: four center-spread depths, four down-spread depths, or no spread. The depth in each case also depends on a 2-bit sub-band index, which says which quarter of the selected input range the reference falls in. All selects pass through one register stage. A new setting takes effect only at a period boundary, so a sweep is never cut short. An active-low power-down stops the sweep and forces the word to zero. When power-down is released, the sweep starts again from the minimum point.

The offset word is continuous control data and is valid on every cycle, so it has no handshake. The consumer samples it whenever it needs it and cannot apply back-pressure. The period-start strobe lets the consumer align to the sweep.

Top module: `ssc_profile_gen`

## Requirements
- R1: Three-level inputs are encoded 2'b00 = low, 2'b01 = middle, 2'b10 = high, and 2'b11 is read as middle. Reset loads middle into the spread and range select registers and 0 into the sub-band register.
- R2: A modulation period lasts 2^BASE_LOG2 reference cycles for range low, twice that for range high, and four times that for range middle. `period_start` is high for exactly one cycle, at phase 0 of each period.
- R3: The center-spread pairs (hi,lo) are, from largest to smallest depth, (low,low), (low,mid), (low,high), (mid,low). Their half-amplitudes in 0.01 % units are 140/120/60/50 for sub-band 0, 130/110/50/40 for sub-band 1, 120/90/50/40 for sub-band 2 and 110/90/40/30 for sub-band 3.
- R4: The down-spread pairs (hi,lo) are, from largest to smallest depth, (high,high), (high,low), (mid,high), (high,mid). Their depths in 0.01 % units are 300/220/190/70 for sub-band 0, 270/190/170/60 for sub-band 1, 250/180/150/60 for sub-band 2 and 230/170/140/50 for sub-band 3.
- R5: The pair (mid,mid) selects no spread: the offset stays 0 for the whole period.
- R6: With half = period/2 and span = 2A for center or A for down, the offset at phase p is min + floor(span*k/half), where k = p for p ≤ half and k = period − p otherwise.
- R7: A center period runs from −A at phase 0 to +A at mid-period. A down period runs from −A up to 0 and never goes above 0.
- R8: `spread_mode` reports the setting of the running period as 2'b00 = none, 2'b01 = center, 2'b10 = down, and never 2'b11.
- R9: A select change alters neither the profile nor the length of the running period. It applies from the next `period_start`.
- R10: While `pwrdn_n` is low, `freq_ofs` is 0, `spread_mode` is 2'b00 and `period_start` is low. On the cycle after `pwrdn_n` returns high, `period_start` is high and the offset is at its minimum.
- R11: During reset all outputs are 0. The first `period_start` appears on the cycle after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous reset, active high |
| pwrdn_n | input | 1 | Power-down, active low |
| spread_hi | input | 2 | Upper three-level spread select |
| spread_lo | input | 2 | Lower three-level spread select |
| range_sel | input | 2 | Three-level input-range select; sets the period length |
| sub_band | input | 2 | Quarter of the selected input range |
| freq_ofs | output | OFS_W | Signed offset, 0.01 % units |
| spread_mode | output | 2 | Setting of the running period |
| period_start | output | 1 | One-cycle strobe at phase 0 |

## Verification
The bench builds the block with BASE_LOG2 = 4 and OFS_W = 16, which gives periods of 16, 32 and 64 cycles. At that size the bench compares every phase of a full period for all nine pin pairs in all four sub-bands, plus each of the three ranges, within a few thousand cycles. The per-cycle step is span shifted left by (2 − range shift), and that amount does not depend on BASE_LOG2. The exact floor values the bench checks therefore carry over unchanged to the default period lengths.

// File: rtl/ssc_pkg.sv
package ssc_pkg;
  localparam int AMP_W = 9;

  typedef enum logic [1:0] {TL_LO = 2'b00, TL_MID = 2'b01, TL_HI = 2'b10} tri_lvl_e;
  typedef enum logic [1:0] {SP_NONE = 2'b00, SP_CENTER = 2'b01, SP_DOWN = 2'b10} spread_e;

  // R1: the unused code reads as middle
  function automatic tri_lvl_e tri_norm(input logic [1:0] raw);
    case (raw)
      2'b00:   return TL_LO;
      2'b10:   return TL_HI;
      default: return TL_MID;
    endcase
  endfunction

  // R3 / R4: depth in 0.01 % units, by {down, sub-band, level}
  function automatic logic [AMP_W-1:0] amp_of(input logic is_down, input logic [1:0] qtr,
                                               input logic [1:0] lvl);
    logic [AMP_W-1:0] v;
    case ({is_down, qtr, lvl})
      5'b0_00_00: v = 9'd140; 5'b0_00_01: v = 9'd120; 5'b0_00_10: v = 9'd60;  5'b0_00_11: v = 9'd50;
      5'b0_01_00: v = 9'd130; 5'b0_01_01: v = 9'd110; 5'b0_01_10: v = 9'd50;  5'b0_01_11: v = 9'd40;
      5'b0_10_00: v = 9'd120; 5'b0_10_01: v = 9'd90;  5'b0_10_10: v = 9'd50;  5'b0_10_11: v = 9'd40;
      5'b0_11_00: v = 9'd110; 5'b0_11_01: v = 9'd90;  5'b0_11_10: v = 9'd40;  5'b0_11_11: v = 9'd30;
      5'b1_00_00: v = 9'd300; 5'b1_00_01: v = 9'd220; 5'b1_00_10: v = 9'd190; 5'b1_00_11: v = 9'd70;
      5'b1_01_00: v = 9'd270; 5'b1_01_01: v = 9'd190; 5'b1_01_10: v = 9'd170; 5'b1_01_11: v = 9'd60;
      5'b1_10_00: v = 9'd250; 5'b1_10_01: v = 9'd180; 5'b1_10_10: v = 9'd150; 5'b1_10_11: v = 9'd60;
      default:    v = 9'd0;
    endcase
    if ({is_down, qtr} == 3'b111) begin
      case (lvl)
        2'd0:    v = 9'd230;
        2'd1:    v = 9'd170;
        2'd2:    v = 9'd140;
        default: v = 9'd50;
      endcase
    end
    return v;
  endfunction
endpackage

// File: rtl/ssc_sel_decode.sv
module ssc_sel_decode
  import ssc_pkg::*;
(
  input  logic [1:0]       spread_hi,
  input  logic [1:0]       spread_lo,
  input  logic [1:0]       range_sel,
  input  logic [1:0]       sub_band,
  output spread_e          mode,
  output logic [AMP_W-1:0] amp,
  output logic [1:0]       rsh
);
  tri_lvl_e h, l, r;
  logic [1:0] lvl;

  always_comb begin
    h = tri_norm(spread_hi);
    l = tri_norm(spread_lo);
    r = tri_norm(range_sel);
    mode = SP_NONE;
    lvl  = 2'd0;
    case ({h, l})
      {TL_LO,  TL_LO }: begin mode = SP_CENTER; lvl = 2'd0; end
      {TL_LO,  TL_MID}: begin mode = SP_CENTER; lvl = 2'd1; end
      {TL_LO,  TL_HI }: begin mode = SP_CENTER; lvl = 2'd2; end
      {TL_MID, TL_LO }: begin mode = SP_CENTER; lvl = 2'd3; end
      {TL_HI,  TL_HI }: begin mode = SP_DOWN;   lvl = 2'd0; end
      {TL_HI,  TL_LO }: begin mode = SP_DOWN;   lvl = 2'd1; end
      {TL_MID, TL_HI }: begin mode = SP_DOWN;   lvl = 2'd2; end
      {TL_HI,  TL_MID}: begin mode = SP_DOWN;   lvl = 2'd3; end
      default:          begin mode = SP_NONE;   lvl = 2'd0; end
    endcase
    amp = (mode == SP_NONE) ? '0 : amp_of(mode == SP_DOWN, sub_band, lvl);
    case (r)
      TL_LO:   rsh = 2'd0;
      TL_HI:   rsh = 2'd1;
      default: rsh = 2'd2;
    endcase
  end
endmodule

// File: rtl/ssc_phase_ctl.sv
module ssc_phase_ctl #(
  parameter int BASE_LOG2 = 7,
  parameter int PH_W      = BASE_LOG2 + 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            pwrdn_n,
  input  logic [1:0]      rsh,
  output logic            run,
  output logic [PH_W-1:0] phase,
  output logic            load,
  output logic            falling
);
  logic [PH_W:0]   dr_len;
  logic [PH_W-1:0] last_ph;
  logic [PH_W-1:0] half_ph;

  always_comb begin
    dr_len  = (PH_W+1)'(1) << (BASE_LOG2 + int'(rsh));
    last_ph = PH_W'(dr_len - (PH_W+1)'(1));
    half_ph = dr_len[PH_W:1];
  end

  assign load    = pwrdn_n && (!run || (phase == last_ph));
  assign falling = (phase >= half_ph);

  always_ff @(posedge clk) begin
    if (rst || !pwrdn_n) begin
      run   <= 1'b0;
      phase <= '0;
    end else if (load) begin
      run   <= 1'b1;
      phase <= '0;
    end else begin
      phase <= phase + PH_W'(1);
    end
  end
endmodule

// File: rtl/ssc_tri_accum.sv
module ssc_tri_accum #(
  parameter int ACC_W = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             load,
  input  logic             falling,
  input  logic [ACC_W-1:0] init,
  input  logic [ACC_W-1:0] step,
  output logic [ACC_W-1:0] acc
);
  always_ff @(posedge clk) begin
    if (rst || clr)   acc <= '0;
    else if (load)    acc <= init;
    else if (falling) acc <= acc - step;
    else              acc <= acc + step;
  end
endmodule

// File: rtl/ssc_profile_gen.sv
module ssc_profile_gen
  import ssc_pkg::*;
#(
  parameter int BASE_LOG2 = 7,
  parameter int OFS_W     = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    pwrdn_n,
  input  logic [1:0]              spread_hi,
  input  logic [1:0]              spread_lo,
  input  logic [1:0]              range_sel,
  input  logic [1:0]              sub_band,
  output logic signed [OFS_W-1:0] freq_ofs,
  output logic [1:0]              spread_mode,
  output logic                    period_start
);
  localparam int FRAC  = BASE_LOG2 + 1;
  localparam int ACC_W = OFS_W + FRAC;
  localparam int PH_W  = BASE_LOG2 + 2;

  logic [1:0] hi_q, lo_q, rng_q, band_q;
  always_ff @(posedge clk) begin
    if (rst) begin
      hi_q   <= TL_MID;
      lo_q   <= TL_MID;
      rng_q  <= TL_MID;
      band_q <= 2'd0;
    end else begin
      hi_q   <= spread_hi;
      lo_q   <= spread_lo;
      rng_q  <= range_sel;
      band_q <= sub_band;
    end
  end

  spread_e          nxt_mode;
  logic [AMP_W-1:0] nxt_amp;
  logic [1:0]       nxt_rsh;

  ssc_sel_decode u_dec (
    .spread_hi (hi_q),
    .spread_lo (lo_q),
    .range_sel (rng_q),
    .sub_band  (band_q),
    .mode      (nxt_mode),
    .amp       (nxt_amp),
    .rsh       (nxt_rsh)
  );

  spread_e          cur_mode;
  logic [AMP_W-1:0] cur_amp;
  logic [1:0]       cur_rsh;
  logic             run, load, falling;
  logic [PH_W-1:0]  phase;

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_mode <= SP_NONE;
      cur_amp  <= '0;
      cur_rsh  <= 2'd2;
    end else if (load) begin
      cur_mode <= nxt_mode;
      cur_amp  <= nxt_amp;
      cur_rsh  <= nxt_rsh;
    end
  end

  ssc_phase_ctl #(.BASE_LOG2(BASE_LOG2), .PH_W(PH_W)) u_phase (
    .clk     (clk),
    .rst     (rst),
    .pwrdn_n (pwrdn_n),
    .rsh     (cur_rsh),
    .run     (run),
    .phase   (phase),
    .load    (load),
    .falling (falling)
  );

  logic [AMP_W:0]   span;
  logic [ACC_W-1:0] step, amp_fx, init, acc;

  always_comb begin
    case (cur_mode)
      SP_CENTER: span = {cur_amp, 1'b0};
      SP_DOWN:   span = {1'b0, cur_amp};
      default:   span = '0;
    endcase
    step   = ACC_W'(span) << (2'd2 - cur_rsh);
    amp_fx = ACC_W'(nxt_amp) << FRAC;
    init   = (nxt_mode == SP_NONE) ? '0 : ('0 - amp_fx);
  end

  ssc_tri_accum #(.ACC_W(ACC_W)) u_acc (
    .clk     (clk),
    .rst     (rst),
    .clr     (!pwrdn_n),
    .load    (load),
    .falling (falling),
    .init    (init),
    .step    (step),
    .acc     (acc)
  );

  logic live;
  assign live         = run && pwrdn_n;
  assign freq_ofs     = live ? acc[FRAC +: OFS_W] : '0;
  assign spread_mode  = live ? cur_mode : SP_NONE;
  assign period_start = live && (phase == '0);
endmodule

// File: rtl/ssc_profile_chk.sv
module ssc_profile_chk
  import ssc_pkg::*;
#(
  parameter int BASE_LOG2 = 7,
  parameter int OFS_W     = 16
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    pwrdn_n,
  input logic signed [OFS_W-1:0] ofs,
  input logic [1:0]              mode,
  input logic                    strobe
);
  localparam int CW = BASE_LOG2 + 4;
  localparam logic [CW-1:0] DR0 = CW'(1) << BASE_LOG2;
  localparam logic [CW-1:0] DR1 = CW'(1) << (BASE_LOG2 + 1);
  localparam logic [CW-1:0] DR2 = CW'(1) << (BASE_LOG2 + 2);

  logic [CW-1:0] gap;
  logic          seen;
  always_ff @(posedge clk) begin
    if (rst || !pwrdn_n) begin
      gap  <= '0;
      seen <= 1'b0;
    end else if (strobe) begin
      gap  <= CW'(1);
      seen <= 1'b1;
    end else begin
      gap <= gap + CW'(1);
    end
  end

  // R2
  period_len_chk: assert property (@(posedge clk) disable iff (rst)
    (strobe && seen) |-> (gap == DR0 || gap == DR1 || gap == DR2));

  // R5
  none_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (mode == SP_NONE) |-> (ofs == '0));

  // R7
  down_le_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (mode == SP_DOWN) |-> ($signed(ofs) <= 0 && $signed(ofs) >= -300));

  // R7
  center_bound_chk: assert property (@(posedge clk) disable iff (rst)
    (mode == SP_CENTER) |-> ($signed(ofs) <= 140 && $signed(ofs) >= -140));

  // R8
  mode_code_chk: assert property (@(posedge clk) disable iff (rst)
    mode != 2'b11);

  // R9
  mode_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!strobe && pwrdn_n && $past(pwrdn_n)) |-> $stable(mode));

  // R10
  pd_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (!pwrdn_n) |-> (ofs == '0 && !strobe && mode == SP_NONE));

  // R10
  pd_restart_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(pwrdn_n) |=> strobe);
endmodule

bind ssc_profile_gen ssc_profile_chk #(.BASE_LOG2(BASE_LOG2), .OFS_W(OFS_W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .pwrdn_n (pwrdn_n),
  .ofs     (freq_ofs),
  .mode    (spread_mode),
  .strobe  (period_start)
);

// File: tb/ssc_profile_gen_tb.sv
module ssc_profile_gen_tb;
  localparam int CLK_PERIOD = 10;
  localparam int TB_LOG2    = 4;
  localparam int OFS_W      = 16;

  logic clk, rst, pwrdn_n;
  logic [1:0] spread_hi, spread_lo, range_sel, sub_band;
  logic signed [OFS_W-1:0] freq_ofs;
  logic [1:0] spread_mode;
  logic period_start;

  ssc_profile_gen #(.BASE_LOG2(TB_LOG2), .OFS_W(OFS_W)) u_dut (
    .clk(clk), .rst(rst), .pwrdn_n(pwrdn_n), .spread_hi(spread_hi), .spread_lo(spread_lo),
    .range_sel(range_sel), .sub_band(sub_band), .freq_ofs(freq_ofs),
    .spread_mode(spread_mode), .period_start(period_start));

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // pin pairs: 0..3 center, 4..7 down, 8 none
  localparam logic [1:0] PHI [9] = '{2'b00, 2'b00, 2'b00, 2'b01, 2'b10, 2'b10, 2'b01, 2'b10, 2'b01};
  localparam logic [1:0] PLO [9] = '{2'b00, 2'b01, 2'b10, 2'b00, 2'b10, 2'b00, 2'b10, 2'b01, 2'b01};
  localparam int CTAB [16] = '{140, 120, 60, 50, 130, 110, 50, 40, 120, 90, 50, 40, 110, 90, 40, 30};
  localparam int DTAB [16] = '{300, 220, 190, 70, 270, 190, 170, 60, 250, 180, 150, 60, 230, 170, 140, 50};

  function automatic logic [1:0] rng_code(int rsh);
    return (rsh == 0) ? 2'b00 : (rsh == 1) ? 2'b10 : 2'b01;
  endfunction

  function automatic int exp_mode(int kind);
    return (kind == 0) ? 1 : (kind == 1) ? 2 : 0;
  endfunction

  function automatic int exp_ofs(int kind, int lvl, int q, int rsh, int p);
    int dr, half, a, mn, span, k;
    dr   = 1 << (TB_LOG2 + rsh);
    half = dr / 2;
    if (kind == 2) return 0;
    a    = (kind == 0) ? CTAB[q*4 + lvl] : DTAB[q*4 + lvl];
    mn   = -a;
    span = (kind == 0) ? 2 * a : a;
    k    = (p <= half) ? p : dr - p;
    return mn + (span * k) / half;
  endfunction

  task automatic chk(bit ok, string tag, int act, int expv);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, expv);
    end
  endtask

  task automatic wait_strobe();
    int guard = 0;
    while (!period_start && guard < 1000) begin
      @(negedge clk);
      guard++;
    end
  endtask

  task automatic set_sel(logic [1:0] hi, logic [1:0] lo, logic [1:0] rng, logic [1:0] q);
    spread_hi = hi;
    spread_lo = lo;
    range_sel = rng;
    sub_band  = q;
  endtask

  // checks one whole period; leaves the bench at the next strobe cycle
  task automatic check_period(int kind, int lvl, int q, int rsh, bit synced, string tag);
    int dr = 1 << (TB_LOG2 + rsh);
    int bad = 0;
    int fa = 0;
    int fe = 0;
    int extra = 0;
    if (!synced) wait_strobe();
    chk(period_start == 1'b1 && int'(spread_mode) == exp_mode(kind), {tag, " mode at start"},
        int'(spread_mode), exp_mode(kind));
    for (int p = 0; p < dr; p++) begin
      int e = exp_ofs(kind, lvl, q, rsh, p);
      int a = int'(freq_ofs);
      if (a != e) begin
        if (bad == 0) begin fa = a; fe = e; end
        bad++;
      end
      if (p > 0 && period_start) extra++;
      @(negedge clk);
    end
    chk(bad == 0, {tag, " profile"}, fa, fe);
    chk(extra == 0 && period_start == 1'b1, {tag, " period length"}, int'(period_start) - extra, 1);
  endtask

  task automatic apply_check(logic [1:0] hi, logic [1:0] lo, int kind, int lvl, int q, int rsh,
                             string tag);
    set_sel(hi, lo, rng_code(rsh), 2'(q));
    wait_strobe();
    @(negedge clk);
    check_period(kind, lvl, q, rsh, 1'b0, tag);
  endtask

  // R11 R1 R5
  task automatic t_reset();
    int bad = 0;
    rst = 1'b1;
    pwrdn_n = 1'b1;
    set_sel(2'b01, 2'b01, 2'b01, 2'b00);
    repeat (3) begin
      @(negedge clk);
      if (freq_ofs != '0 || spread_mode != 2'b00 || period_start) bad++;
    end
    chk(bad == 0, "R11 outputs zero in reset", bad, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(period_start == 1'b1, "R11 first strobe after release", int'(period_start), 1);
    check_period(2, 0, 0, 2, 1'b1, "R1 R5 reset defaults middle");
  endtask

  // R3 R4 R5 R6 R8
  task automatic t_codes();
    for (int q = 0; q < 4; q++) begin
      for (int i = 0; i < 9; i++) begin
        int kind = (i < 4) ? 0 : (i < 8) ? 1 : 2;
        apply_check(PHI[i], PLO[i], kind, i % 4, q, 0,
                    $sformatf("%s R6 R8 pair%0d band%0d", (kind == 0) ? "R3" : (kind == 1) ? "R4" : "R5", i, q));
      end
    end
  endtask

  // R2
  task automatic t_ranges();
    apply_check(PHI[0], PLO[0], 0, 0, 1, 1, "R2 range high");
    apply_check(PHI[5], PLO[5], 1, 1, 2, 2, "R2 range middle");
    apply_check(PHI[2], PLO[2], 0, 2, 3, 0, "R2 range low");
  endtask

  // R7
  task automatic t_peaks(int idx, int kind, int q, int expmin, int expmax, string tag);
    int mn = 100000;
    int mx = -100000;
    set_sel(PHI[idx], PLO[idx], 2'b10, 2'(q));
    wait_strobe();
    @(negedge clk);
    wait_strobe();
    for (int p = 0; p < 32; p++) begin
      if (int'(freq_ofs) < mn) mn = int'(freq_ofs);
      if (int'(freq_ofs) > mx) mx = int'(freq_ofs);
      @(negedge clk);
    end
    chk(mn == expmin, {tag, " minimum"}, mn, expmin);
    chk(mx == expmax, {tag, " maximum"}, mx, expmax);
  endtask

  // R9
  task automatic t_defer();
    int bad = 0;
    int fa = 0;
    int fe = 0;
    apply_check(PHI[0], PLO[0], 0, 0, 0, 0, "R9 setup");
    repeat (3) @(negedge clk);
    set_sel(PHI[4], PLO[4], rng_code(1), 2'b00);
    for (int p = 3; p < 16; p++) begin
      int e = exp_ofs(0, 0, 0, 0, p);
      if (int'(freq_ofs) != e || period_start || spread_mode != 2'b01) begin
        if (bad == 0) begin fa = int'(freq_ofs); fe = e; end
        bad++;
      end
      @(negedge clk);
    end
    chk(bad == 0, "R9 running period keeps old setting", fa, fe);
    check_period(1, 0, 0, 1, 1'b1, "R9 new setting at next strobe");
  endtask

  // R10
  task automatic t_pwrdn();
    int bad = 0;
    apply_check(PHI[1], PLO[1], 0, 1, 2, 0, "R10 setup");
    repeat (5) @(negedge clk);
    pwrdn_n = 1'b0;
    #1;
    chk(freq_ofs == '0 && spread_mode == 2'b00 && !period_start, "R10 immediate zero",
        int'(freq_ofs), 0);
    repeat (4) begin
      @(negedge clk);
      if (freq_ofs != '0 || spread_mode != 2'b00 || period_start) bad++;
    end
    chk(bad == 0, "R10 held quiet", bad, 0);
    pwrdn_n = 1'b1;
    @(negedge clk);
    chk(period_start == 1'b1, "R10 strobe after release", int'(period_start), 1);
    check_period(0, 1, 2, 0, 1'b1, "R10 restart from minimum");
  endtask

  // R1
  task automatic t_code11();
    apply_check(2'b11, 2'b11, 2, 0, 0, 0, "R1 code 11 pair as middle");
    apply_check(2'b00, 2'b11, 0, 1, 0, 0, "R1 code 11 low pin as middle");
    set_sel(2'b00, 2'b00, 2'b11, 2'b01);
    wait_strobe();
    @(negedge clk);
    check_period(0, 0, 1, 2, 1'b0, "R1 code 11 range as middle");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired act=hung exp=done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_codes();
    t_ranges();
    t_peaks(0, 0, 0, -140, 140, "R7 center");
    t_peaks(4, 1, 0, -300, 0, "R7 down");
    t_defer();
    t_pwrdn();
    t_code11();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule